// File: doc/BRIEF.md
# I2C Status Flag and Address-Match Unit

This unit keeps the status byte of an I2C controller, next to a separate shift engine that handles the bus itself. The shift engine sends it single-cycle event strobes:

- bus START and STOP conditions,
- each received data bit,
- the acknowledge clock,
- the end of an address byte and the end of a data byte.

With those strobes come the sampled and driven SDA levels and the completed byte. From these the unit keeps five flags:

- the last received bit,
- a general-call flag,
- an own-address match flag,
- an arbitration-lost flag,
- a bus-busy flag.

It also keeps the master and transmit mode bits. A small register write port loads the own-address register and updates the writable status bits. Writes to the data shift register or the transmit buffer register are seen here only for their side effect: they clear the match flags.

Address compare runs only on the first address byte after a START. It also runs only when the unit acts as a slave, or when it was master and lost arbitration during that byte. This lets a master that loses arbitration still recognise its own address sent by the winning master. Arbitration loss drops the transmit bit in the next cycle. The master bit is kept until the byte in which the loss occurred has ended.

Top module: `i2c_stat_unit`

## Requirements
- R1: After reset the status byte, `mst` and `trx` are all 0.
- R2: Status bit 0 takes `sda_in` on every `ev_bit`. When `ack_mode`=1, an `ev_ack` loads `sda_in` into bit 0, so 0 means acknowledged and 1 means not acknowledged. When `ack_mode`=0, `ev_ack` leaves bit 0 unchanged.
- R3: A write with `wr_sel`=1 (data shift register) or `wr_sel`=2 (transmit buffer) clears status bit 0 and bit 2 in the next cycle. This clear wins over a set in the same cycle.
- R4: Status bit 1 (general call) is set when the first address byte after START is 0x00 and compare is enabled. Any START or STOP clears it, and the clear wins over a set.
- R5: With `ten_bit`=0, status bit 2 (match) is set when bits 7:1 of the first address byte after START equal bits 7:1 of the own-address register, or when that byte is 0x00. Later address bytes before the next START never set it.
- R6: With `ten_bit`=1, status bit 2 is set only when the first address byte equals all 8 bits of the own-address register. A general call still sets bit 1 in this mode.
- R7: When `mst`=1 and `trx`=1, an `ev_bit` with `sda_drv`=1 and `sda_in`=0 sets status bit 3 (arbitration lost) and clears `trx` in the next cycle.
- R8: After an arbitration loss, `mst` stays 1 through further bit strobes. It clears on the next `ev_addr` or `ev_data`.
- R9: While `mst`=1 and no loss has occurred in the current byte, address bytes are not compared. If arbitration was lost during the first address byte, that byte is compared as a slave would compare it.
- R10: Status bit 3 stays set until a status write (`wr_sel`=3), or until a START while `mst`=1. Either clear wins over a set.
- R11: A status write loads bit 7 (`mst`), bit 6 (`trx`) and bit 4 (a general-purpose control bit) from `wr_data`. Bits 0 to 3 and bit 5 ignore the write. A write with `wr_sel`=0 loads the own-address register and leaves the status byte unchanged.
- R12: Status bit 5 (bus busy) is set by START and cleared by STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | START condition detected (one-cycle strobe) |
| ev_stop | input | 1 | STOP condition detected (one-cycle strobe) |
| ev_bit | input | 1 | Data or address bit sampled (one-cycle strobe) |
| ev_ack | input | 1 | Acknowledge clock (one-cycle strobe) |
| ev_addr | input | 1 | Address byte complete (one-cycle strobe) |
| ev_data | input | 1 | Data byte complete (one-cycle strobe) |
| sda_in | input | 1 | Sampled SDA level |
| sda_drv | input | 1 | Level this device drives on SDA (1 = released) |
| rx_byte | input | 8 | Completed received byte, valid with `ev_addr` |
| ack_mode | input | 1 | 1: acknowledge clock loads bit 0 |
| ten_bit | input | 1 | 1: 10-bit first-byte compare, 0: 7-bit compare |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 own address, 1 data shift, 2 transmit buffer, 3 status |
| wr_data | input | 8 | Write data |
| status | output | 8 | Status byte: 7 mst, 6 trx, 5 busy, 4 control, 3 arb lost, 2 match, 1 general call, 0 last bit |
| mst | output | 1 | Master mode |
| trx | output | 1 | Transmit mode |

## Verification
The embedded properties assume that the shift engine raises at most one event strobe per cycle. They also assume that an arbitration-loss bit strobe never falls in the same cycle as an end-of-byte strobe. The bench drives each strobe alone for one cycle and then returns all strobes to zero. It therefore never combines events, except for the same-cycle priority cases that the properties check directly. The address compare is swept over all 256 received byte values, in both compare modes, against several own addresses.

// File: rtl/i2c_stat_pkg.sv
// Package: shared constants and types for the I2C status unit.
// Assumes an 8-bit register width on the host side.
package i2c_stat_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_SHIFT = 2'd1,
        SEL_TXBUF = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    localparam int B_LRB   = 0;
    localparam int B_GC    = 1;
    localparam int B_MATCH = 2;
    localparam int B_AL    = 3;
    localparam int B_USER  = 4;
    localparam int B_BUSY  = 5;
    localparam int B_TRX   = 6;
    localparam int B_MST   = 7;
endpackage

// File: rtl/i2c_stat_addr_cmp.sv
// Module: combinational first-byte address comparator.
// Compares a received byte with the own address in 7-bit form (upper bits
// only, general call accepted) or in 10-bit first-byte form (all bits).
// GC_IN_TEN selects whether a general call also hits in 10-bit mode.
// Assumes rx_byte and own_addr are stable in the cycle they are used.
module i2c_stat_addr_cmp #(
    parameter int W         = 8,
    parameter bit GC_IN_TEN = 1'b0
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] own_addr,
    input  logic         ten_bit,
    output logic         is_gc,
    output logic         hit
);
    logic hit7;
    logic hit10;
    logic gc_ten;

    // Decode the general-call byte and both compare forms.
    always_comb begin
        is_gc = (rx_byte == '0);
        hit7  = (rx_byte[W-1:1] == own_addr[W-1:1]);
        hit10 = (rx_byte == own_addr);
    end

    generate
        if (GC_IN_TEN) begin : g_gc_ten
            assign gc_ten = is_gc;
        end else begin : g_no_gc_ten
            assign gc_ten = 1'b0;
        end
    endgenerate

    // Pick the compare form for the selected address format.
    always_comb begin
        hit = ten_bit ? (hit10 | gc_ten) : (hit7 | is_gc);
    end
endmodule

// File: rtl/i2c_stat_rxflags.sv
// Module: receive-side status flags (last bit, general call, address match,
// bus busy) and the first-address-byte tracker.
// Assumes single-cycle event strobes, at most one bus event per cycle.
module i2c_stat_rxflags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_bit,
    input  logic ev_ack,
    input  logic ev_addr,
    input  logic ack_mode,
    input  logic sda_in,
    input  logic clr_wr,
    input  logic cmp_en,
    input  logic is_gc,
    input  logic hit,
    output logic lrb,
    output logic gc,
    output logic match,
    output logic busy,
    output logic first_pend
);
    logic take;

    // An address byte is compared only if it is the first after START.
    always_comb begin
        take = ev_addr && first_pend && cmp_en;
    end

    // Track whether the next address byte is the first one after START.
    always_ff @(posedge clk) begin
        if (!rst_n)        first_pend <= 1'b0;
        else if (ev_start) first_pend <= 1'b1;
        else if (ev_addr)  first_pend <= 1'b0;
    end

    // Last received bit, or the acknowledge level in ack mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lrb <= 1'b0;
        else if (clr_wr)              lrb <= 1'b0;
        else if (ev_ack && ack_mode)  lrb <= sda_in;
        else if (ev_bit)              lrb <= sda_in;
    end

    // General-call flag: set on a zero first byte, cleared by START/STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gc <= 1'b0;
        else if (ev_start || ev_stop) gc <= 1'b0;
        else if (take && is_gc)       gc <= 1'b1;
    end

    // Address-match flag: set on a hit, cleared by data register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)            match <= 1'b0;
        else if (clr_wr)       match <= 1'b0;
        else if (take && hit)  match <= 1'b1;
    end

    // Bus-busy flag between START and STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (ev_stop)  busy <= 1'b0;
        else if (ev_start) busy <= 1'b1;
    end

    assert_lrb_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !lrb);
    assert_match_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !match);
    assert_gc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start || ev_stop) |=> !gc);
    assert_match_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ev_addr && first_pend)) |=> !$rose(match));
    assert_busy_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !busy);
endmodule

// File: rtl/i2c_stat_arb.sv
// Module: arbitration-loss detection and mode bits (master, transmit,
// general control bit). Transmit drops at once on loss; master drops at
// the end of the byte in which the loss occurred.
// Assumes a loss strobe never shares a cycle with an end-of-byte strobe.
module i2c_stat_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_bit,
    input  logic byte_end,
    input  logic sda_in,
    input  logic sda_drv,
    input  logic stat_wr,
    input  logic wr_mst,
    input  logic wr_trx,
    input  logic wr_user,
    output logic al,
    output logic mst,
    output logic trx,
    output logic user,
    output logic lost_pend
);
    logic loss;
    logic al_clr;

    // Loss: released SDA reads low while transmitting as master.
    always_comb begin
        loss   = ev_bit && mst && trx && sda_drv && !sda_in;
        al_clr = stat_wr || (ev_start && mst);
    end

    // Arbitration-lost flag, held until software or an own START clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      al <= 1'b0;
        else if (al_clr) al <= 1'b0;
        else if (loss)   al <= 1'b1;
    end

    // Marks that the byte in progress has lost arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n)        lost_pend <= 1'b0;
        else if (ev_start) lost_pend <= 1'b0;
        else if (loss)     lost_pend <= 1'b1;
        else if (byte_end) lost_pend <= 1'b0;
    end

    // Transmit bit: hardware loss clear wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       trx <= 1'b0;
        else if (loss)    trx <= 1'b0;
        else if (stat_wr) trx <= wr_trx;
    end

    // Master bit: dropped when the lost byte ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mst <= 1'b0;
        else if (byte_end && lost_pend)  mst <= 1'b0;
        else if (stat_wr)                mst <= wr_mst;
    end

    // General-purpose control bit, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)       user <= 1'b0;
        else if (stat_wr) user <= wr_user;
    end

    assert_trx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loss |=> !trx);
    assert_al_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loss && !al_clr) |=> al);
    assert_mst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mst && !byte_end && !stat_wr) |=> mst);
    assert_mst_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_pend && byte_end) |=> !mst);
    assert_al_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> !al);
endmodule

// File: rtl/i2c_stat_unit.sv
// Module: top of the I2C status flag and address-match unit.
// Holds the own-address register, decodes register writes, assembles the
// status byte. Assumes event strobes come from a shift engine, one per cycle.
module i2c_stat_unit
    import i2c_stat_pkg::*;
#(
    parameter bit GC_IN_TEN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_bit,
    input  logic              ev_ack,
    input  logic              ev_addr,
    input  logic              ev_data,
    input  logic              sda_in,
    input  logic              sda_drv,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ack_mode,
    input  logic              ten_bit,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] status,
    output logic              mst,
    output logic              trx
);
    reg_sel_e          sel;
    logic              stat_wr;
    logic              clr_wr;
    logic              addr_wr;
    logic [BYTE_W-1:0] own_addr;
    logic              is_gc, hit;
    logic              lrb, gc, match, busy, first_pend;
    logic              al, user, lost_pend;
    logic              cmp_en;

    // Decode which register a write targets.
    always_comb begin
        sel     = reg_sel_e'(wr_sel);
        stat_wr = wr_en && (sel == SEL_STAT);
        addr_wr = wr_en && (sel == SEL_ADDR);
        clr_wr  = wr_en && ((sel == SEL_SHIFT) || (sel == SEL_TXBUF));
        cmp_en  = !mst || lost_pend;
    end

    // Own-address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       own_addr <= '0;
        else if (addr_wr) own_addr <= wr_data;
    end

    i2c_stat_addr_cmp #(.W(BYTE_W), .GC_IN_TEN(GC_IN_TEN)) u_cmp (
        .rx_byte  (rx_byte),
        .own_addr (own_addr),
        .ten_bit  (ten_bit),
        .is_gc    (is_gc),
        .hit      (hit)
    );

    i2c_stat_rxflags u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_bit     (ev_bit),
        .ev_ack     (ev_ack),
        .ev_addr    (ev_addr),
        .ack_mode   (ack_mode),
        .sda_in     (sda_in),
        .clr_wr     (clr_wr),
        .cmp_en     (cmp_en),
        .is_gc      (is_gc),
        .hit        (hit),
        .lrb        (lrb),
        .gc         (gc),
        .match      (match),
        .busy       (busy),
        .first_pend (first_pend)
    );

    i2c_stat_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (ev_start),
        .ev_bit    (ev_bit),
        .byte_end  (ev_addr || ev_data),
        .sda_in    (sda_in),
        .sda_drv   (sda_drv),
        .stat_wr   (stat_wr),
        .wr_mst    (wr_data[B_MST]),
        .wr_trx    (wr_data[B_TRX]),
        .wr_user   (wr_data[B_USER]),
        .al        (al),
        .mst       (mst),
        .trx       (trx),
        .user      (user),
        .lost_pend (lost_pend)
    );

    // Assemble the readable status byte.
    always_comb begin
        status          = '0;
        status[B_LRB]   = lrb;
        status[B_GC]    = gc;
        status[B_MATCH] = match;
        status[B_AL]    = al;
        status[B_USER]  = user;
        status[B_BUSY]  = busy;
        status[B_TRX]   = trx;
        status[B_MST]   = mst;
    end

    assert_master_no_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr && mst && !lost_pend && !clr_wr) |=> $stable(match));
    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop) |=> busy);
endmodule

// File: tb/i2c_stat_unit_tb.sv
`timescale 1ns/1ps
module i2c_stat_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 0, ev_stop = 0, ev_bit = 0, ev_ack = 0, ev_addr = 0, ev_data = 0;
    logic       sda_in = 1, sda_drv = 1;
    logic [7:0] rx_byte = 0;
    logic       ack_mode = 0, ten_bit = 0;
    logic       wr_en = 0;
    logic [1:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] status;
    logic       mst, trx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    i2c_stat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_bit(ev_bit), .ev_ack(ev_ack), .ev_addr(ev_addr), .ev_data(ev_data),
        .sda_in(sda_in), .sda_drv(sda_drv), .rx_byte(rx_byte),
        .ack_mode(ack_mode), .ten_bit(ten_bit), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .mst(mst), .trx(trx)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic do_stop();
        @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask
    task automatic do_bit(input logic s_in, input logic s_drv);
        @(negedge clk); ev_bit = 1; sda_in = s_in; sda_drv = s_drv;
        @(negedge clk); ev_bit = 0; sda_in = 1; sda_drv = 1;
    endtask
    task automatic do_ack(input logic s_in);
        @(negedge clk); ev_ack = 1; sda_in = s_in;
        @(negedge clk); ev_ack = 0; sda_in = 1;
    endtask
    task automatic do_addr(input logic [7:0] b);
        @(negedge clk); ev_addr = 1; rx_byte = b;
        @(negedge clk); ev_addr = 0; rx_byte = 0;
    endtask
    task automatic do_data(input logic [7:0] b);
        @(negedge clk); ev_data = 1; rx_byte = b;
        @(negedge clk); ev_data = 0; rx_byte = 0;
    endtask
    task automatic do_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 0; wr_sel = 0; wr_data = 0;
    endtask

    task automatic sweep(input logic [7:0] own, input logic tb10);
        do_wr(2'd0, own);
        ten_bit = tb10;
        for (int b = 0; b < 256; b++) begin
            logic exp_m, exp_g;
            exp_g = (b == 0);
            exp_m = tb10 ? (b[7:0] == own) : ((b[7:1] == own[7:1]) || exp_g);
            do_start();
            chk("R12 busy after START", {7'd0, status[5]}, 8'd1);
            do_addr(b[7:0]);
            chk(tb10 ? "R6 first byte compare" : "R5 first byte compare",
                {6'd0, status[2:1]}, {6'd0, exp_m, exp_g});
            do_addr(own);
            chk("R5 later byte ignored", {7'd0, status[2]}, {7'd0, exp_m});
            do_stop();
            chk("R4 STOP clears gc / R12 busy", {6'd0, status[5], status[1]}, 8'd0);
            do_wr(2'd1, 8'h00);
            chk("R3 shift write clears match", {7'd0, status[2]}, 8'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 mode", {6'd0, mst, trx}, 8'h00);

        // R11 status write: only bits 7,6,4 take effect
        do_wr(2'd3, 8'hFF);
        chk("R11 write ones", status, 8'hD0);
        do_wr(2'd3, 8'h00);
        chk("R11 write zeros", status, 8'h00);
        do_wr(2'd0, 8'hA4);
        chk("R11 address write leaves status", status, 8'h00);

        // R2 last received bit and ack handling
        do_bit(1, 1);
        chk("R2 bit one", {7'd0, status[0]}, 8'd1);
        do_bit(0, 1);
        chk("R2 bit zero", {7'd0, status[0]}, 8'd0);
        ack_mode = 1;
        do_ack(1);
        chk("R2 ack mode nack", {7'd0, status[0]}, 8'd1);
        do_ack(0);
        chk("R2 ack mode ack", {7'd0, status[0]}, 8'd0);
        ack_mode = 0;
        do_ack(1);
        chk("R2 ack clock ignored", {7'd0, status[0]}, 8'd0);

        // R3 writes to shift and transmit buffer clear bit 0
        do_bit(1, 1);
        do_wr(2'd1, 8'h55);
        chk("R3 shift clears lrb", {7'd0, status[0]}, 8'd0);
        do_bit(1, 1);
        do_wr(2'd2, 8'h55);
        chk("R3 txbuf clears lrb", {7'd0, status[0]}, 8'd0);

        // R4 R5 R6 R12 address sweeps
        sweep(8'hA4, 1'b0);
        sweep(8'h3F, 1'b0);
        sweep(8'hF1, 1'b1);
        sweep(8'h00, 1'b1);
        ten_bit = 0;
        do_wr(2'd0, 8'hA4);

        // R9 master without loss does not compare
        do_wr(2'd3, 8'hC0);
        do_start();
        do_addr(8'hA4);
        chk("R9 master no compare", {6'd0, status[2:1]}, 8'd0);
        chk("R9 master kept", {6'd0, mst, trx}, 8'd3);

        // R7 R8 arbitration loss in a data byte
        do_bit(1, 1);
        chk("R7 no loss when SDA high", {7'd0, status[3]}, 8'd0);
        do_bit(0, 0);
        chk("R7 no loss when driving low", {7'd0, status[3]}, 8'd0);
        do_bit(0, 1);
        chk("R7 loss sets flag", {7'd0, status[3]}, 8'd1);
        chk("R7 loss clears trx", {6'd0, mst, trx}, 8'd2);
        do_bit(1, 1);
        do_bit(0, 1);
        chk("R8 mst held mid byte", {7'd0, mst}, 8'd1);
        do_data(8'h12);
        chk("R8 mst cleared at byte end", {7'd0, mst}, 8'd0);
        chk("R10 flag held after byte", {7'd0, status[3]}, 8'd1);
        do_start();
        chk("R10 slave START keeps flag", {7'd0, status[3]}, 8'd1);
        do_wr(2'd3, 8'h00);
        chk("R10 status write clears flag", {7'd0, status[3]}, 8'd0);

        // R10 START as master clears flag
        do_wr(2'd3, 8'hC0);
        do_bit(0, 1);
        chk("R7 second loss", {7'd0, status[3]}, 8'd1);
        do_start();
        chk("R10 master START clears flag", {7'd0, status[3]}, 8'd0);
        do_stop();

        // R9 loss during address byte: own address recognised
        do_wr(2'd3, 8'hC0);
        do_start();
        do_bit(0, 1);
        do_addr(8'hA5);
        chk("R9 lost address compared", {7'd0, status[2]}, 8'd1);
        chk("R9 becomes slave receiver", {6'd0, mst, trx}, 8'd0);
        do_stop();
        do_wr(2'd2, 8'h00);
        chk("R3 txbuf clears match", {7'd0, status[2]}, 8'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule